// File: doc/BRIEF.md
# LIN Status Flags and Interrupt Logic

This block holds the sticky status flags of a LIN/UART controller and produces its interrupt request. A protocol engine (outside this block) sends one-cycle event pulses when a header has been sent or received, when the first data byte of a response group has arrived, and when any of seven error kinds is detected. Each event sets a flag that stays set until software clears it. A read-only aggregate error bit shows whether any error flag is set.

Software clears flags through a write port that acts only on bits written as 0. Bits written as 1 keep their value. The aggregate error bit cannot be written. It falls only after every individual error flag has been cleared. When a received response is longer than eight bytes, software clears the data flag between groups so that it can be set again. In receive mode, software clears the header flag after reading it so that the next header is seen.

The block has two enable bits, one for headers and one for errors. A single interrupt output pulses for one cycle when an enabled flag goes from 0 to 1. An event that arrives while its flag is already set raises no interrupt.

Top module: `lin_flag_irq`

## Requirements
- R1: A synchronous active-low reset (rst_n sampled low at a clock edge) clears all status flags, both enable bits and irq by the following cycle.
- R2: A pulse on ev_hdr_tx or ev_hdr_rx sets status bit 0 (header done) in the next cycle.
- R3: A pulse on ev_data1 sets status bit 1 (first data byte received). This flag never causes irq.
- R4: ev_err[k] sets status bit 2+k, with k ordered parity, ID parity, checksum, sync field, framing, timeout, bit error. Status bit 9 reads 1 exactly when any of bits 8:2 is 1.
- R5: When stat_wr is high, each status bit 8:0 whose stat_wdata bit is 0 is cleared. A stat_wdata bit of 1 leaves its flag unchanged. Status bit 9 is not affected by the written value.
- R6: If a set event and a clearing write reach the same flag in the same cycle, the flag ends up set.
- R7: irq is high in the cycle after a header event if status bit 0 was 0 and ien bit 0 (header enable) was 1. A header event while bit 0 is already 1 gives no irq.
- R8: irq is high in the cycle after an error event if status bit 9 was 0 and ien bit 1 (error enable) was 1. An error event while bit 9 is already 1 gives no irq.
- R9: irq is high only in a cycle where status bit 0 or status bit 9 has just risen from 0 to 1. An event held high for several cycles therefore gives a single-cycle irq.
- R10: When en_wr is high, ien takes the value of en_wdata in the next cycle. Bit 0 is the header enable and bit 1 is the error enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_hdr_tx | input | 1 | Header transmission completed pulse |
| ev_hdr_rx | input | 1 | Header reception completed pulse |
| ev_data1 | input | 1 | First data byte of a group received pulse |
| ev_err | input | ERR_W (7) | Individual error detection pulses |
| stat_wr | input | 1 | Status write strobe (write-0-to-clear) |
| stat_wdata | input | ERR_W+2 (9) | Status write data for bits 8:0 |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | 2 | Enable write data |
| stat_q | output | ERR_W+3 (10) | Status flags; bit 9 is the aggregate error bit |
| ien_q | output | 2 | Current interrupt enables |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
Every result is registered once. The flags, the enables and irq all change at the first rising edge after the stimulus, and the aggregate bit follows in that same cycle. The bench drives inputs at the falling edge. It advances a reference model computed from the requirements by one step, then samples at the next falling edge, so each comparison lands exactly one cycle after its stimulus. Directed sequences cover set-versus-clear collisions, repeated events on flags that are already set, and a partial clear of the error flags. The rest of the run uses seeded random events and writes.

// File: rtl/lin_flag_irq.sv
module lin_flag_irq #(
  parameter int ERR_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ev_hdr_tx,
  input  logic               ev_hdr_rx,
  input  logic               ev_data1,
  input  logic [ERR_W-1:0]   ev_err,
  input  logic               stat_wr,
  input  logic [ERR_W+1:0]   stat_wdata,
  input  logic               en_wr,
  input  logic [1:0]         en_wdata,
  output logic [ERR_W+2:0]   stat_q,
  output logic [1:0]         ien_q,
  output logic               irq
);
  localparam int SW = ERR_W + 2;

  logic [SW-1:0] flg;
  logic [1:0]    ien;
  logic          irq_r;

  wire           hdr_ev  = ev_hdr_tx | ev_hdr_rx;
  wire [SW-1:0]  set_v   = {ev_err, ev_data1, hdr_ev};
  wire [SW-1:0]  clr_v   = stat_wr ? ~stat_wdata : '0;
  wire           err_any = |flg[SW-1:2];
  wire           hdr_up  = hdr_ev & ~flg[0] & ien[0];
  wire           err_up  = (|ev_err) & ~err_any & ien[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flg   <= '0;
      ien   <= '0;
      irq_r <= 1'b0;
    end else begin
      flg   <= set_v | (flg & ~clr_v);
      irq_r <= hdr_up | err_up;
      if (en_wr) ien <= en_wdata;
    end
  end

  assign stat_q = {err_any, flg};
  assign ien_q  = ien;
  assign irq    = irq_r;
endmodule

module lin_flag_irq_chk #(
  parameter int ERR_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ev_hdr_tx,
  input logic             ev_hdr_rx,
  input logic             ev_data1,
  input logic [ERR_W-1:0] ev_err,
  input logic             stat_wr,
  input logic [ERR_W+1:0] stat_wdata,
  input logic [ERR_W+2:0] stat_q,
  input logic [1:0]       ien_q,
  input logic             irq
);
  localparam int AG = ERR_W + 2;

  assert_reset_clears_R1: assert property (@(posedge clk)
    !rst_n |=> (stat_q == '0 && ien_q == '0 && !irq));

  assert_hdr_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_hdr_tx || ev_hdr_rx) |=> stat_q[0]);

  assert_data1_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_data1 && !ev_hdr_tx && !ev_hdr_rx && ev_err == '0) |=> !irq);

  assert_agg_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[AG]) |-> $past(|ev_err));

  assert_write_one_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && stat_wdata[0] && !ev_hdr_tx && !ev_hdr_rx) |=> (stat_q[0] == $past(stat_q[0])));

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_data1 && stat_wr && !stat_wdata[1]) |=> stat_q[1]);

  assert_hdr_no_repeat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[0] && stat_q[AG] && !stat_wr) |=> !irq);

  assert_err_no_repeat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[AG] && !(ev_hdr_tx || ev_hdr_rx)) |=> !irq);

  assert_irq_on_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((stat_q[0] && !$past(stat_q[0])) || (stat_q[AG] && !$past(stat_q[AG]))));
endmodule

bind lin_flag_irq lin_flag_irq_chk #(.ERR_W(ERR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_hdr_tx(ev_hdr_tx), .ev_hdr_rx(ev_hdr_rx),
  .ev_data1(ev_data1), .ev_err(ev_err), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
  .stat_q(stat_q), .ien_q(ien_q), .irq(irq)
);

// File: tb/lin_flag_irq_test.sv
`timescale 1ns/1ps
module lin_flag_irq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ev_hdr_tx = 0, ev_hdr_rx = 0, ev_data1 = 0;
  logic [6:0] ev_err = '0;
  logic       stat_wr = 0;
  logic [8:0] stat_wdata = '0;
  logic       en_wr = 0;
  logic [1:0] en_wdata = '0;
  logic [9:0] stat_q;
  logic [1:0] ien_q;
  logic       irq;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [8:0] m_flg = '0;
  logic [1:0] m_ien = '0;
  logic       m_irq = 0;

  always #5 clk = ~clk;

  lin_flag_irq uut (
    .clk(clk), .rst_n(rst_n), .ev_hdr_tx(ev_hdr_tx), .ev_hdr_rx(ev_hdr_rx),
    .ev_data1(ev_data1), .ev_err(ev_err), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
    .en_wr(en_wr), .en_wdata(en_wdata), .stat_q(stat_q), .ien_q(ien_q), .irq(irq)
  );

  function automatic logic [9:0] exp_stat();
    return {(m_flg[8:2] != 0), m_flg};
  endfunction

  task automatic check(string tag, logic [9:0] act, logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    logic [8:0] nf;
    logic [1:0] ni;
    logic       nq;
    logic       hdr = ev_hdr_tx | ev_hdr_rx;
    if (!rst_n) begin
      nf = '0; ni = '0; nq = 0;
    end else begin
      nf = m_flg;
      if (stat_wr)
        for (int i = 0; i < 9; i++) if (!stat_wdata[i]) nf[i] = 1'b0;
      if (hdr) nf[0] = 1'b1;
      if (ev_data1) nf[1] = 1'b1;
      for (int i = 0; i < 7; i++) if (ev_err[i]) nf[2+i] = 1'b1;
      ni = en_wr ? en_wdata : m_ien;
      nq = (hdr && !m_flg[0] && m_ien[0]) || ((ev_err != 0) && (m_flg[8:2] == 0) && m_ien[1]);
    end
    @(negedge clk);
    m_flg = nf; m_ien = ni; m_irq = nq;
  endtask

  task automatic idle();
    ev_hdr_tx = 0; ev_hdr_rx = 0; ev_data1 = 0; ev_err = '0;
    stat_wr = 0; stat_wdata = '0; en_wr = 0; en_wdata = '0;
  endtask

  task automatic check_all(string tag);
    check({tag, " stat"}, stat_q, exp_stat());
    check({tag, " irq"}, {9'b0, irq}, {9'b0, m_irq});
    check({tag, " ien"}, {8'b0, ien_q}, {8'b0, m_ien});
  endtask

  initial begin
    int unused;
    unused = $urandom(32'd4242);
    idle();
    @(negedge clk); step(); step();
    check_all("R1 reset");
    rst_n = 1;

    en_wr = 1; en_wdata = 2'b11; step(); idle();
    check("R10 enable write", {8'b0, ien_q}, 10'h003);

    ev_hdr_tx = 1; step(); idle();
    check("R2 header flag", {9'b0, stat_q[0]}, 10'h1);
    check("R7 header irq", {9'b0, irq}, 10'h1);
    step();
    check("R9 single pulse", {9'b0, irq}, 10'h0);

    ev_hdr_rx = 1; step(); step(); idle();
    check("R7 no irq while set", {9'b0, irq}, 10'h0);

    stat_wr = 1; stat_wdata = 9'h1FF; step(); idle();
    check("R5 write one ignored", stat_q, 10'h001);

    stat_wr = 1; stat_wdata = 9'h1FE; ev_hdr_rx = 1; step(); idle();
    check("R6 set wins", {9'b0, stat_q[0]}, 10'h1);

    stat_wr = 1; stat_wdata = 9'h1FE; step(); idle();
    check("R5 write zero clears", stat_q, 10'h000);

    ev_data1 = 1; step(); idle();
    check("R3 data1 flag", stat_q, 10'h002);
    check("R3 data1 no irq", {9'b0, irq}, 10'h0);

    ev_err = 7'b0010000; step(); idle();
    check("R4 framing flag and aggregate", stat_q, 10'h242);
    check("R8 error irq", {9'b0, irq}, 10'h1);

    ev_err = 7'b0000001; step(); idle();
    check("R8 no irq while aggregate set", {9'b0, irq}, 10'h0);

    stat_wr = 1; stat_wdata = 9'h1BF; step(); idle();
    check("R4 aggregate held by parity", stat_q, 10'h206);

    stat_wr = 1; stat_wdata = 9'h003; step(); idle();
    check("R4 aggregate clears", stat_q, 10'h002);
    check("R5 aggregate ignores write", {9'b0, stat_q[9]}, 10'h0);

    stat_wr = 1; stat_wdata = 9'h1FD; step(); idle();
    ev_data1 = 1; step(); idle();
    check("R3 data1 next group", stat_q, 10'h002);

    en_wr = 1; en_wdata = 2'b00; step(); idle();
    ev_err = 7'b1000000; ev_hdr_tx = 1; step(); idle();
    check("R8 disabled error no irq", {9'b0, irq}, 10'h0);
    check("R7 disabled header no irq", stat_q, 10'h303);

    for (int n = 0; n < 3000; n++) begin
      ev_hdr_tx  = ($urandom % 10) == 0;
      ev_hdr_rx  = ($urandom % 10) == 0;
      ev_data1   = ($urandom % 8) == 0;
      for (int b = 0; b < 7; b++) ev_err[b] = ($urandom % 24) == 0;
      stat_wr    = ($urandom % 3) == 0;
      stat_wdata = 9'($urandom);
      en_wr      = ($urandom % 8) == 0;
      en_wdata   = 2'($urandom);
      rst_n      = ($urandom % 400) != 0;
      step();
      check("R4 random stat", stat_q, exp_stat());
      check("R9 random irq", {9'b0, irq}, {9'b0, m_irq});
      check("R10 random ien", {8'b0, ien_q}, {8'b0, m_ien});
    end

    idle(); rst_n = 0; step(); rst_n = 1;
    check_all("R1 late reset");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule